// File: doc/BRIEF.md
# Acknowledge-Polling Sequencer

After a host has finished writing to a serial memory and sent the stop, the memory runs a self-timed internal write. During that write it does not acknowledge its address. This sequencer finds out when the memory is ready by probing it, not by waiting a fixed time. Each probe is a start condition followed by the memory's slave address with the direction bit cleared. If the address byte is not acknowledged, the sequencer starts a new probe. When the address byte is acknowledged, the sequencer prepares the bus for the next access:
- If the next access is a write, it sends the byte address and leaves the bus open.
- If the next access is a read, it sends a stop.

The block controls a byte-level two-wire master through a command handshake. It offers three commands: start, send byte (which returns the acknowledge bit), and stop. It does not generate the bus bits itself.

The host gives the sequencer a job with a one-cycle `start_i` pulse while `ready_o` is high. The job carries:
- the device address;
- the byte address;
- a flag saying whether the next access is a write;
- a probe limit.

When the job ends, `done_o` pulses for one cycle. The probe count and a timeout flag are then valid. The timeout flag is set when the limit ran out without an acknowledge.

Top module: `ackpoll_seq`

## Requirements
- R1: Out of reset, `ready_o`=1 and `cmd_valid_o`=0, `done_o`=0, `poll_cnt_o`=0, `timeout_o`=0.
- R2: `start_i` is accepted only while `ready_o`=1. On acceptance, the sequencer captures `next_wr_i`, `byte_addr_i`, `dev_addr_i` and `max_polls_i`. A `start_i` pulse while a job runs has no effect on that job, and later changes to these inputs also have no effect.
- R3: Every probe is a start command followed by a byte command. The data of that byte command is `{dev_addr_i, 1'b0}`, so bit 0 (the read/write bit) is 0.
- R4: A command is offered with `cmd_valid_o`=1 and `cmd_o` (0 = start, 1 = byte, 2 = stop). `cmd_valid_o`, `cmd_o` and `cmd_data_o` hold steady until the cycle in which `cmd_done_i`=1. In that cycle `cmd_ack_i`=1 reports an acknowledge for a byte command.
- R5: If the address byte gets no acknowledge and the limit is not used up, the next command is a new start. No stop is sent between probes.
- R6: If the address byte is acknowledged and the captured next-access flag is 1, the sequencer sends one byte command carrying the captured byte address. It then finishes without a stop.
- R7: If the address byte is acknowledged and the captured next-access flag is 0, the sequencer sends exactly one stop and then finishes.
- R8: If the address byte gets no acknowledge on the probe whose number equals a nonzero limit, `timeout_o` becomes 1 and one stop is sent before finishing. An acknowledge on that same probe counts as success.
- R9: A limit of 0 means probing continues until the device acknowledges.
- R10: `poll_cnt_o` counts the accepted start commands of the current job and saturates at all ones. `poll_cnt_o` and `timeout_o` are cleared when a job is accepted and stay stable after `done_o` until the next accepted job.
- R11: `done_o` is high for exactly one cycle, and `ready_o` is 1 in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Job request, one-cycle pulse |
| next_wr_i | input | 1 | 1 when the following access is a write |
| byte_addr_i | input | DATA_W | Byte address sent on a successful write path |
| dev_addr_i | input | DATA_W-1 | Device slave address |
| max_polls_i | input | CNT_W | Probe limit, 0 for no limit |
| ready_o | output | 1 | Idle, can accept a job |
| done_o | output | 1 | Job finished, one-cycle pulse |
| timeout_o | output | 1 | Job ended without an acknowledge |
| poll_cnt_o | output | CNT_W | Probes issued in the last or current job |
| cmd_valid_o | output | 1 | Command offered to the byte master |
| cmd_o | output | 2 | Command code: 0 start, 1 byte, 2 stop |
| cmd_data_o | output | DATA_W | Byte to transmit for a byte command |
| cmd_done_i | input | 1 | Byte master completed the offered command |
| cmd_ack_i | input | 1 | Acknowledge received for a completed byte command |

## Verification
Two decisions can fall in the same cycle: the acknowledge on an address byte and the end of the probe limit. When the last permitted address byte completes, the sequencer must choose between success and timeout from that one handshake. The stimulus tables set the number of refused probes to exactly one less than the limit, and also equal to the limit. The results are judged by whether `timeout_o` rises and by how many start, stop and byte-address commands reach the byte-master model. The tables also push the byte master's response latency from zero to several cycles, so command holding and the restart after a refusal are covered both back to back and under stall.

// File: rtl/ackpoll_pkg.sv
package ackpoll_pkg;
  typedef enum logic [1:0] {
    CMD_START = 2'd0,
    CMD_BYTE  = 2'd1,
    CMD_STOP  = 2'd2
  } cmd_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START,
    ST_SADDR,
    ST_WADDR,
    ST_STOP,
    ST_DONE
  } state_e;
endpackage

// File: rtl/ackpoll_cnt.sv
module ackpoll_cnt #(
  parameter int CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             inc_i,
  input  logic [CNT_W-1:0] limit_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             last_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                       cnt_q <= '0;
    else if (clr_i)                    cnt_q <= '0;
    else if (inc_i && cnt_q != CNT_MAX) cnt_q <= cnt_q + 1'b1;
  end

  // limit of zero never ends the job
  assign last_o = (limit_i != '0) && (cnt_q >= limit_i);
  assign cnt_o  = cnt_q;
endmodule

// File: rtl/ackpoll_cmd.sv
module ackpoll_cmd
  import ackpoll_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  state_e            state_i,
  input  logic [DATA_W-2:0] dev_i,
  input  logic [DATA_W-1:0] baddr_i,
  output logic              valid_o,
  output cmd_e              cmd_o,
  output logic [DATA_W-1:0] data_o
);
  always_comb begin
    valid_o = 1'b1;
    cmd_o   = CMD_START;
    data_o  = '0;
    unique case (state_i)
      ST_START: cmd_o = CMD_START;
      ST_SADDR: begin
        cmd_o  = CMD_BYTE;
        data_o = {dev_i, 1'b0};  // direction bit: write
      end
      ST_WADDR: begin
        cmd_o  = CMD_BYTE;
        data_o = baddr_i;
      end
      ST_STOP:  cmd_o = CMD_STOP;
      default:  valid_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/ackpoll_fsm.sv
module ackpoll_fsm
  import ackpoll_pkg::*;
(
  input  logic   clk_i,
  input  logic   rst_ni,
  input  logic   go_i,
  input  logic   wr_i,
  input  logic   last_i,
  input  logic   fire_i,
  input  logic   ack_i,
  output state_e state_o
);
  state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:  if (go_i)   state_d = ST_START;
      ST_START: if (fire_i) state_d = ST_SADDR;
      ST_SADDR: if (fire_i) begin
        if (ack_i)       state_d = wr_i ? ST_WADDR : ST_STOP;
        else if (last_i) state_d = ST_STOP;
        else             state_d = ST_START;
      end
      ST_WADDR: if (fire_i) state_d = ST_DONE;
      ST_STOP:  if (fire_i) state_d = ST_DONE;
      ST_DONE:  state_d = ST_IDLE;
      default:  state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_IDLE;
    else         state_q <= state_d;
  end

  assign state_o = state_q;
endmodule

// File: rtl/ackpoll_seq.sv
module ackpoll_seq
  import ackpoll_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int CNT_W  = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              next_wr_i,
  input  logic [DATA_W-1:0] byte_addr_i,
  input  logic [DATA_W-2:0] dev_addr_i,
  input  logic [CNT_W-1:0]  max_polls_i,
  output logic              ready_o,
  output logic              done_o,
  output logic              timeout_o,
  output logic [CNT_W-1:0]  poll_cnt_o,
  output logic              cmd_valid_o,
  output logic [1:0]        cmd_o,
  output logic [DATA_W-1:0] cmd_data_o,
  input  logic              cmd_done_i,
  input  logic              cmd_ack_i
);
  state_e            state;
  cmd_e              cmd;
  logic              accept, fire, last, nak_out;
  logic              wr_q, tmo_q;
  logic [DATA_W-1:0] baddr_q;
  logic [DATA_W-2:0] dev_q;
  logic [CNT_W-1:0]  lim_q;

  assign ready_o = (state == ST_IDLE);
  assign done_o  = (state == ST_DONE);
  assign accept  = ready_o && start_i;
  assign fire    = cmd_valid_o && cmd_done_i;
  assign nak_out = (state == ST_SADDR) && fire && !cmd_ack_i && last;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_q    <= 1'b0;
      baddr_q <= '0;
      dev_q   <= '0;
      lim_q   <= '0;
      tmo_q   <= 1'b0;
    end else if (accept) begin
      wr_q    <= next_wr_i;
      baddr_q <= byte_addr_i;
      dev_q   <= dev_addr_i;
      lim_q   <= max_polls_i;
      tmo_q   <= 1'b0;
    end else if (nak_out) begin
      tmo_q   <= 1'b1;
    end
  end

  ackpoll_fsm u_fsm (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .go_i    (accept),
    .wr_i    (wr_q),
    .last_i  (last),
    .fire_i  (fire),
    .ack_i   (cmd_ack_i),
    .state_o (state)
  );

  ackpoll_cnt #(.CNT_W(CNT_W)) u_cnt (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clr_i   (accept),
    .inc_i   ((state == ST_START) && fire),
    .limit_i (lim_q),
    .cnt_o   (poll_cnt_o),
    .last_o  (last)
  );

  ackpoll_cmd #(.DATA_W(DATA_W)) u_cmd (
    .state_i (state),
    .dev_i   (dev_q),
    .baddr_i (baddr_q),
    .valid_o (cmd_valid_o),
    .cmd_o   (cmd),
    .data_o  (cmd_data_o)
  );

  assign cmd_o     = cmd;
  assign timeout_o = tmo_q;
endmodule

// File: rtl/ackpoll_seq_chk.sv
module ackpoll_seq_chk #(
  parameter int DATA_W = 8,
  parameter int CNT_W  = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              ready_o,
  input logic              done_o,
  input logic              timeout_o,
  input logic [CNT_W-1:0]  poll_cnt_o,
  input logic              cmd_valid_o,
  input logic [1:0]        cmd_o,
  input logic [DATA_W-1:0] cmd_data_o,
  input logic              cmd_done_i,
  input logic              cmd_ack_i
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic fire, in_probe;
  assign fire = cmd_valid_o && cmd_done_i;

  // tracks the byte that directly follows a start
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                      in_probe <= 1'b0;
    else if (fire && cmd_o == 2'd0)   in_probe <= 1'b1;
    else if (fire)                    in_probe <= 1'b0;
  end

  assert_cmd_hold_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_valid_o && !cmd_done_i |=> cmd_valid_o && $stable(cmd_o) && $stable(cmd_data_o));

  assert_rw_zero_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_valid_o && cmd_o == 2'd1 && in_probe |-> cmd_data_o[0] == 1'b0);

  assert_nak_restart_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fire && cmd_o == 2'd1 && in_probe && !cmd_ack_i |=>
      cmd_valid_o && (cmd_o == 2'd0 || (cmd_o == 2'd2 && timeout_o)));

  assert_poll_step_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fire && cmd_o == 2'd0 && poll_cnt_o != CNT_MAX |=> poll_cnt_o == $past(poll_cnt_o) + 1'b1);

  assert_done_pulse_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> ready_o && !done_o);

  assert_idle_quiet_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_o |-> !cmd_valid_o && !done_o);
endmodule

bind ackpoll_seq ackpoll_seq_chk #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_chk (.*);

// File: tb/ackpoll_seq_tb.sv
module ackpoll_seq_tb;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       start_i = 1'b0;
  logic       next_wr_i = 1'b0;
  logic [7:0] byte_addr_i = '0;
  logic [6:0] dev_addr_i = '0;
  logic [7:0] max_polls_i = '0;
  logic       ready_o, done_o, timeout_o, cmd_valid_o;
  logic [7:0] poll_cnt_o;
  logic [1:0] cmd_o;
  logic [7:0] cmd_data_o;
  logic       cmd_done_i = 1'b0;
  logic       cmd_ack_i = 1'b0;

  int n_chk = 0, n_fail = 0;

  // byte-master model state
  int         nak_n, lat, wait_c;
  int         n_start, n_saddr, n_waddr, n_stop, bad_sa;
  bit         after_s;
  logic [7:0] waddr_v;
  logic [6:0] exp_dev;

  always #10 clk_i = ~clk_i;

  ackpoll_seq u_dut (.*);

  // nak(8) lim(8) wr(1) baddr(8) dev(7) lat(3)
  localparam logic [34:0] VECS [8] = '{
    {8'd0, 8'd4, 1'b1, 8'hA5, 7'h50, 3'd0},
    {8'd3, 8'd8, 1'b0, 8'h3C, 7'h51, 3'd2},
    {8'd5, 8'd3, 1'b1, 8'h77, 7'h52, 3'd0},
    {8'd2, 8'd3, 1'b1, 8'h0F, 7'h53, 3'd1},
    {8'd3, 8'd3, 1'b0, 8'hF0, 7'h54, 3'd0},
    {8'd9, 8'd0, 1'b0, 8'h12, 7'h55, 3'd1},
    {8'd0, 8'd1, 1'b0, 8'h99, 7'h56, 3'd3},
    {8'd1, 8'd1, 1'b1, 8'h44, 7'h57, 3'd2}
  };

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // byte-master model
  initial begin
    forever begin
      @(negedge clk_i);
      if (cmd_done_i) begin
        cmd_done_i = 1'b0;
        wait_c = 0;
      end else if (cmd_valid_o) begin
        if (wait_c >= lat) begin
          cmd_done_i = 1'b1;
          cmd_ack_i  = 1'b0;
          case (cmd_o)
            2'd0: begin n_start++; after_s = 1'b1; end
            2'd1: begin
              if (after_s) begin
                if (cmd_data_o != {exp_dev, 1'b0}) bad_sa++;
                cmd_ack_i = (n_saddr >= nak_n);
                n_saddr++;
              end else begin
                n_waddr++;
                waddr_v   = cmd_data_o;
                cmd_ack_i = 1'b1;
              end
              after_s = 1'b0;
            end
            default: n_stop++;
          endcase
        end else wait_c++;
      end
    end
  end

  task automatic run_case(input int nak, input int lim, input bit wr, input logic [7:0] ba,
                          input logic [6:0] dv, input int lt, input bit poke);
    int p, guard;
    bit ok;
    @(negedge clk_i);
    n_start = 0; n_saddr = 0; n_waddr = 0; n_stop = 0; bad_sa = 0;
    after_s = 1'b0; wait_c = 0; waddr_v = '0;
    nak_n = nak; lat = lt; exp_dev = dv;
    next_wr_i = wr; byte_addr_i = ba; dev_addr_i = dv; max_polls_i = 8'(lim);
    start_i = 1'b1;
    @(negedge clk_i);
    start_i = 1'b0;
    if (poke) begin
      repeat (3) @(negedge clk_i);
      // R2: second request while busy with altered inputs
      start_i = 1'b1; next_wr_i = ~wr; max_polls_i = 8'd1; byte_addr_i = ~ba;
      @(negedge clk_i);
      start_i = 1'b0;
    end
    guard = 0;
    while (!done_o && guard < 20000) begin
      @(negedge clk_i);
      guard++;
    end
    chk(done_o, "R11 done seen", int'(done_o), 1);
    p  = (lim != 0 && nak + 1 > lim) ? lim : nak + 1;
    ok = (nak < p);
    chk(n_start == p, "R5/R9 probe starts", n_start, p);
    chk(poll_cnt_o == 8'((p > 255) ? 255 : p), "R10 poll count", int'(poll_cnt_o), (p > 255) ? 255 : p);
    chk(timeout_o == !ok, "R8 timeout flag", int'(timeout_o), int'(!ok));
    chk(n_stop == ((!ok || !wr) ? 1 : 0), "R7/R8 stop count", n_stop, (!ok || !wr) ? 1 : 0);
    chk(n_waddr == ((ok && wr) ? 1 : 0), "R6 addr byte count", n_waddr, (ok && wr) ? 1 : 0);
    if (ok && wr) chk(waddr_v == ba, "R6 addr byte value", int'(waddr_v), int'(ba));
    chk(bad_sa == 0, "R3 slave byte", bad_sa, 0);
    @(negedge clk_i);
    chk(ready_o && !done_o, "R11 ready after done", int'({ready_o, done_o}), 2);
    chk(poll_cnt_o == 8'((p > 255) ? 255 : p) && timeout_o == !ok, "R10 held after done",
        int'(poll_cnt_o), (p > 255) ? 255 : p);
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    n_fail++;
    $display("FAIL watchdog actual=0 expected=1");
    $display("%0d/%0d checks passed", n_chk + 1 - n_fail, n_chk + 1);
    $finish;
  end

  initial begin
    nak_n = 0; lat = 0; wait_c = 0; exp_dev = '0;
    repeat (3) @(negedge clk_i);
    // R1: during and after reset
    chk(ready_o && !cmd_valid_o && !done_o, "R1 reset idle", int'({ready_o, cmd_valid_o, done_o}), 4);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk(poll_cnt_o == 0 && !timeout_o, "R1 reset counters", int'(poll_cnt_o), 0);
    chk(ready_o && !cmd_valid_o, "R1 idle after release", int'({ready_o, cmd_valid_o}), 2);

    foreach (VECS[i]) begin
      run_case(int'(VECS[i][34:27]), int'(VECS[i][26:19]), VECS[i][18], VECS[i][17:10],
               VECS[i][9:3], int'(VECS[i][2:0]), 1'b0);
    end

    // R2: request while busy is ignored
    run_case(2, 0, 1'b0, 8'h5A, 7'h2B, 2, 1'b1);
    run_case(4, 6, 1'b1, 8'hC3, 7'h11, 1, 1'b1);
    // R10/R9: saturation with unlimited probing
    run_case(300, 0, 1'b1, 8'h81, 7'h7F, 0, 1'b0);
    // R8: limit at maximum, ack on the last allowed probe
    run_case(254, 255, 1'b0, 8'h01, 7'h01, 0, 1'b0);

    // R4: command held while the master stalls
    @(negedge clk_i);
    nak_n = 0; lat = 1000; wait_c = 0; exp_dev = 7'h33; after_s = 1'b0;
    next_wr_i = 1'b0; dev_addr_i = 7'h33; max_polls_i = 8'd2; start_i = 1'b1;
    @(negedge clk_i);
    start_i = 1'b0;
    repeat (10) @(negedge clk_i);
    chk(cmd_valid_o && cmd_o == 2'd0, "R4 start held under stall", int'(cmd_o), 0);
    lat = 0;
    repeat (3) @(negedge clk_i);
    chk(cmd_valid_o && cmd_o == 2'd1 && cmd_data_o == 8'h66, "R3 slave byte after start",
        int'(cmd_data_o), 8'h66);
    while (!ready_o) @(negedge clk_i);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule